// File: doc/BRIEF.md
# Flash Erase Status Engine

This block runs the embedded erase of a parallel NOR flash on behalf of a command sequencer. The sequencer hands it a whole-chip erase, or one or more sector erases each tagged with an address. A suspend command and a resume command can also arrive. The block turns each address into a sector number. Sector geometry comes from up to four regions, and each region has its own block count and its own sector size given as a power of two. The block selects the sectors to erase and times two phases. The first phase is a short window in which more sectors may join the erase. The second phase is the erase itself. When the erase ends, the block pulses a done output and presents the mask of selected sectors, so that the array owner can fill those sectors with all-ones.

While an erase is running, any read of the flash must return a status word instead of array data. The block tells the read path which of the two to return. It also supplies the status word. One bit of that word flips on every read while the erase runs. A second bit flips as well, and it keeps flipping during a suspend, but only for reads that land in a sector being erased. A third bit shows whether the window for adding sectors has closed. Program operations complete at once and are not handled here.

Top module: `flash_erase_status`

## Requirements
- R1: After reset, busy_o, done_o and rd_status_o are 0 and erase_mask_o is all zeros.
- R2: After a sector erase starts, reads return status with bit 7 at 0 and bit 3 at 0 for ACCEPT_CYC cycles. Bit 3 then reads 1 for the rest of the erase.
- R3: While erasing and not suspended, each read strobe flips status bits 6 and 2. This holds at any address, inside or outside the selected sectors.
- R4: A sector erase command received during the accept window adds that sector to erase_mask_o and restarts the window. A sector erase command received after the window closes is ignored.
- R5: Mask bit numbering follows ascending address. Region 0 comes first, then regions 1, 2 and 3. With the default geometry (7×64, 1×32, 2×8 and 1×16 words), word 447 maps to bit 6, 448 to bit 7, 485 to bit 8, 490 to bit 9 and 500 to bit 10.
- R6: A suspend command is accepted both in the window and after it. While suspended, a read inside a selected sector returns status with bit 6 held and bit 2 flipping. A read outside the selected sectors returns rd_status_o at 0.
- R7: A sector erase command given while suspended acts as resume and adds no sector. After resume, bit 3 reads 1, status is returned at every address again, and the erase-time count continues. Suspended cycles are not counted as erase time.
- R8: After the window, the erase lasts ERASE_CYC cycles. It then ends with a one-cycle done_o pulse, and erase_mask_o holds the selected sectors. Reads then return rd_status_o at 0.
- R9: A chip erase selects every sector, has no accept window (bit 3 reads 1 at once), ignores suspend, and completes ERASE_CYC+1 cycles after it is issued.
- R10: A suspend command while idle does nothing. A chip erase command while busy does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_erase_i | input | 1 | Chip erase request pulse |
| sect_erase_i | input | 1 | Sector erase request pulse; resume while suspended |
| suspend_i | input | 1 | Erase suspend pulse |
| cmd_addr_i | input | AW (9) | Word address of a sector erase command |
| rd_i | input | 1 | Read strobe, one per read |
| rd_addr_i | input | AW (9) | Word address of the read |
| rd_status_o | output | 1 | Read must return status_o instead of array data |
| status_o | output | 8 | Status word (bit 7 poll, bit 6 toggle, bit 3 window closed, bit 2 suspend toggle) |
| busy_o | output | 1 | Erase in progress or suspended |
| done_o | output | 1 | One-cycle pulse when the erase ends |
| erase_mask_o | output | NSECT (11) | Sectors selected for the current or last erase |

## Verification
A single sector is erased with reads at its own address and at an unrelated address. This separates status that toggles everywhere from status that toggles only at the selected sector. A burst of erase commands inside the window, and a late command after it, show whether the window restarts and whether late commands are dropped. The exact completion cycle confirms this. Suspends placed inside the window and after it tell the held toggle bit from the flipping one, and they check that paused cycles are left out of the erase time. Addresses at region edges test the sector map, and a chip erase with a suspend applied confirms that this path has no window and cannot be suspended.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCEPT = 2'd1,
    ST_BUSY   = 2'd2,
    ST_SUSP   = 2'd3
  } fes_state_e;

  localparam int unsigned NUM_REG   = 4;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned BIT_POLL  = 7;
  localparam int unsigned BIT_TOG   = 6;
  localparam int unsigned BIT_WIN   = 3;
  localparam int unsigned BIT_STOG  = 2;
endpackage

// File: rtl/fes_sector_map.sv
module fes_sector_map #(
  parameter int unsigned R0_BLOCKS = 7,
  parameter int unsigned R0_SHIFT  = 6,
  parameter int unsigned R1_BLOCKS = 1,
  parameter int unsigned R1_SHIFT  = 5,
  parameter int unsigned R2_BLOCKS = 2,
  parameter int unsigned R2_SHIFT  = 3,
  parameter int unsigned R3_BLOCKS = 1,
  parameter int unsigned R3_SHIFT  = 4,
  parameter int unsigned AW        = 9,
  parameter int unsigned NSECT     = 11
) (
  input  logic [AW-1:0]    addr_i,
  output logic [NSECT-1:0] sel_o
);
  localparam int unsigned IW = (NSECT > 1) ? $clog2(NSECT) : 1;
  localparam int unsigned BLK [fes_pkg::NUM_REG] = '{R0_BLOCKS, R1_BLOCKS, R2_BLOCKS, R3_BLOCKS};
  localparam int unsigned SH  [fes_pkg::NUM_REG] = '{R0_SHIFT, R1_SHIFT, R2_SHIFT, R3_SHIFT};

  function automatic int unsigned words_below(input int unsigned r);
    int unsigned s = 0;
    for (int unsigned i = 0; i < fes_pkg::NUM_REG; i++)
      if (i < r) s += BLK[i] << SH[i];
    return s;
  endfunction

  function automatic int unsigned blocks_below(input int unsigned r);
    int unsigned s = 0;
    for (int unsigned i = 0; i < fes_pkg::NUM_REG; i++)
      if (i < r) s += BLK[i];
    return s;
  endfunction

  logic [31:0]   a32;
  logic [fes_pkg::NUM_REG-1:0] hit;
  logic [IW-1:0] idx [fes_pkg::NUM_REG];

  assign a32 = 32'(addr_i);

  for (genvar r = 0; r < fes_pkg::NUM_REG; r++) begin : g_reg
    localparam int unsigned BASE_A = words_below(r);
    localparam int unsigned BASE_B = blocks_below(r);
    localparam int unsigned SPAN   = BLK[r] << SH[r];
    if (BLK[r] == 0) begin : g_empty
      assign hit[r] = 1'b0;
      assign idx[r] = '0;
    end else begin : g_used
      assign hit[r] = (a32 >= BASE_A) && (a32 < BASE_A + SPAN);
      assign idx[r] = IW'(BASE_B + ((a32 - BASE_A) >> SH[r]));
    end
  end

  always_comb begin
    sel_o = '0;
    for (int r = 0; r < fes_pkg::NUM_REG; r++)
      if (hit[r]) sel_o = sel_o | (NSECT'(1) << idx[r]);
  end
endmodule

// File: rtl/fes_timer.sv
module fes_timer #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fes_toggle.sv
module fes_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (en_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/flash_erase_status.sv
module flash_erase_status #(
  parameter int unsigned R0_BLOCKS  = 7,
  parameter int unsigned R0_SHIFT   = 6,
  parameter int unsigned R1_BLOCKS  = 1,
  parameter int unsigned R1_SHIFT   = 5,
  parameter int unsigned R2_BLOCKS  = 2,
  parameter int unsigned R2_SHIFT   = 3,
  parameter int unsigned R3_BLOCKS  = 1,
  parameter int unsigned R3_SHIFT   = 4,
  parameter int unsigned ACCEPT_CYC = 16,
  parameter int unsigned ERASE_CYC  = 64,
  localparam int unsigned NSECT   = R0_BLOCKS + R1_BLOCKS + R2_BLOCKS + R3_BLOCKS,
  localparam int unsigned TOTAL_W = (R0_BLOCKS << R0_SHIFT) + (R1_BLOCKS << R1_SHIFT)
                                  + (R2_BLOCKS << R2_SHIFT) + (R3_BLOCKS << R3_SHIFT),
  localparam int unsigned AW      = (TOTAL_W > 1) ? $clog2(TOTAL_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chip_erase_i,
  input  logic             sect_erase_i,
  input  logic             suspend_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             rd_status_o,
  output logic [7:0]       status_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [NSECT-1:0] erase_mask_o
);
  import fes_pkg::*;

  localparam int unsigned MAXC = (ACCEPT_CYC > ERASE_CYC) ? ACCEPT_CYC : ERASE_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] ACC_LD = TW'(ACCEPT_CYC - 1);
  localparam logic [TW-1:0] ERS_LD = TW'(ERASE_CYC - 1);

  fes_state_e       state_q, state_d;
  logic [NSECT-1:0] sel_q, sel_d, cmd_sel, rd_sel;
  logic             chip_q, chip_d, done_d;
  logic             tmr_ld, tmr_run, tmr_zero;
  logic [TW-1:0]    tmr_val;
  logic             t6_q, t2_q, rd_in_sel, active, t6_en, t2_en;

  fes_sector_map #(
    .R0_BLOCKS(R0_BLOCKS), .R0_SHIFT(R0_SHIFT), .R1_BLOCKS(R1_BLOCKS), .R1_SHIFT(R1_SHIFT),
    .R2_BLOCKS(R2_BLOCKS), .R2_SHIFT(R2_SHIFT), .R3_BLOCKS(R3_BLOCKS), .R3_SHIFT(R3_SHIFT),
    .AW(AW), .NSECT(NSECT)
  ) i_cmd_map (.addr_i(cmd_addr_i), .sel_o(cmd_sel));

  fes_sector_map #(
    .R0_BLOCKS(R0_BLOCKS), .R0_SHIFT(R0_SHIFT), .R1_BLOCKS(R1_BLOCKS), .R1_SHIFT(R1_SHIFT),
    .R2_BLOCKS(R2_BLOCKS), .R2_SHIFT(R2_SHIFT), .R3_BLOCKS(R3_BLOCKS), .R3_SHIFT(R3_SHIFT),
    .AW(AW), .NSECT(NSECT)
  ) i_rd_map (.addr_i(rd_addr_i), .sel_o(rd_sel));

  fes_timer #(.W(TW)) i_timer (
    .clk_i, .rst_ni, .load_i(tmr_ld), .load_val_i(tmr_val), .run_i(tmr_run), .zero_o(tmr_zero)
  );

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    chip_d  = chip_q;
    done_d  = 1'b0;
    tmr_ld  = 1'b0;
    tmr_val = ERS_LD;
    tmr_run = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (chip_erase_i) begin
          state_d = ST_BUSY;
          sel_d   = '1;
          chip_d  = 1'b1;
          tmr_ld  = 1'b1;
        end else if (sect_erase_i && |cmd_sel) begin
          state_d = ST_ACCEPT;
          sel_d   = cmd_sel;
          chip_d  = 1'b0;
          tmr_ld  = 1'b1;
          tmr_val = ACC_LD;
        end
      end
      ST_ACCEPT: begin
        if (suspend_i) begin
          // window closes on suspend; erase time starts fresh at resume
          state_d = ST_SUSP;
          tmr_ld  = 1'b1;
        end else if (sect_erase_i && |cmd_sel) begin
          sel_d   = sel_q | cmd_sel;
          tmr_ld  = 1'b1;
          tmr_val = ACC_LD;
        end else if (tmr_zero) begin
          state_d = ST_BUSY;
          tmr_ld  = 1'b1;
        end else begin
          tmr_run = 1'b1;
        end
      end
      ST_BUSY: begin
        if (suspend_i && !chip_q) begin
          state_d = ST_SUSP;
        end else if (tmr_zero) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          tmr_run = 1'b1;
        end
      end
      ST_SUSP: begin
        if (sect_erase_i) state_d = ST_BUSY;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      chip_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      chip_q  <= chip_d;
      done_o  <= done_d;
    end
  end

  assign active    = (state_q == ST_ACCEPT) || (state_q == ST_BUSY);
  assign rd_in_sel = |(rd_sel & sel_q);
  assign t6_en     = rd_i && active;
  assign t2_en     = rd_i && (active || (state_q == ST_SUSP && rd_in_sel));

  fes_toggle i_tog6 (.clk_i, .rst_ni, .en_i(t6_en), .q_o(t6_q));
  fes_toggle i_tog2 (.clk_i, .rst_ni, .en_i(t2_en), .q_o(t2_q));

  assign rd_status_o = active || (state_q == ST_SUSP && rd_in_sel);

  always_comb begin
    status_o = '0;
    if (rd_status_o) begin
      status_o[BIT_TOG]  = t6_q;
      status_o[BIT_STOG] = t2_q;
      status_o[BIT_WIN]  = (state_q != ST_ACCEPT);
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign erase_mask_o = sel_q;
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int unsigned NSECT = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chip_erase_i,
  input logic             sect_erase_i,
  input logic             suspend_i,
  input logic             rd_i,
  input logic             rd_status_o,
  input logic [7:0]       status_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [NSECT-1:0] erase_mask_o,
  input logic [1:0]       state_i,
  input logic             t6_i,
  input logic             t2_i
);
  import fes_pkg::*;

  logic running;
  assign running = (state_i == ST_ACCEPT) || (state_i == ST_BUSY);

  assert_poll_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_o |-> !status_o[BIT_POLL]);

  assert_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && running) |=> (t6_i != $past(t6_i)) && (t2_i != $past(t2_i)));

  assert_susp_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state_i == ST_SUSP) |=> (t6_i == $past(t6_i)));

  assert_mask_grow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ((erase_mask_o & $past(erase_mask_o)) == $past(erase_mask_o)));

  assert_done_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_chip_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_erase_i && !busy_o) |=> (busy_o && (&erase_mask_o)));

  assert_idle_susp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && !busy_o && !chip_erase_i && !sect_erase_i) |=> !busy_o);
endmodule

bind flash_erase_status fes_checker #(.NSECT(NSECT)) i_fes_checker (
  .clk_i, .rst_ni, .chip_erase_i, .sect_erase_i, .suspend_i, .rd_i,
  .rd_status_o, .status_o, .busy_o, .done_o, .erase_mask_o,
  .state_i(state_q), .t6_i(t6_q), .t2_i(t2_q)
);

// File: tb/test_flash_erase_status.sv
module test_flash_erase_status;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int NS = 11;
  localparam int ACC = 16;
  localparam int ERS = 64;
  localparam int SECT_DUR = ACC + ERS + 1;
  localparam int CHIP_DUR = ERS + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic chip_erase_i = 0, sect_erase_i = 0, suspend_i = 0, rd_i = 0;
  logic [AW-1:0] cmd_addr_i = '0, rd_addr_i = '0;
  logic rd_status_o, busy_o, done_o;
  logic [7:0] status_o;
  logic [NS-1:0] erase_mask_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] rs_st;
  logic rs_v;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flash_erase_status i_flash_erase_status (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  task automatic sect(input int a, output int c0);
    cmd_addr_i = AW'(a); sect_erase_i = 1; c0 = cyc; step(); sect_erase_i = 0;
  endtask

  task automatic chip(output int c0);
    chip_erase_i = 1; c0 = cyc; step(); chip_erase_i = 0;
  endtask

  task automatic susp(output int c0);
    suspend_i = 1; c0 = cyc; step(); suspend_i = 0;
  endtask

  task automatic rd(input int a);
    rd_addr_i = AW'(a); rd_i = 1; #1;
    rs_v = rd_status_o; rs_st = status_o;
    step(); rd_i = 0;
  endtask

  task automatic wait_done(input int c0, output int dur);
    dur = -1;
    for (int i = 0; i < 2000; i++) begin
      if (done_o) begin dur = cyc - c0; break; end
      step();
    end
  endtask

  task automatic t_reset;
    rd_addr_i = '0; #1;
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!done_o, "R1 done", done_o, 0);
    chk(!rd_status_o, "R1 status sel", rd_status_o, 0);
    chk(erase_mask_o == '0, "R1 mask", erase_mask_o, 0);
  endtask

  task automatic t_single;
    int c0, dur; logic [7:0] s0;
    sect(0, c0);
    rd(0);
    chk(rs_v, "R2 status returned", rs_v, 1);
    chk(rs_st[7] == 0, "R2 bit7", rs_st[7], 0);
    chk(rs_st[3] == 0, "R2 bit3 in window", rs_st[3], 0);
    s0 = rs_st;
    rd(0);
    chk(rs_st[6] == ~s0[6], "R3 bit6 flip", rs_st[6], ~s0[6]);
    chk(rs_st[2] == ~s0[2], "R3 bit2 flip", rs_st[2], ~s0[2]);
    s0 = rs_st;
    rd(200);
    chk(rs_v, "R3 other sector status", rs_v, 1);
    chk(rs_st[6] == ~s0[6] && rs_st[2] == ~s0[2], "R3 other sector flip", rs_st, s0 ^ 8'h44);
    step(20);
    rd(0);
    chk(rs_st[3] == 1, "R2 bit3 after window", rs_st[3], 1);
    chk(rs_st[7] == 0, "R2 bit7 busy", rs_st[7], 0);
    wait_done(c0, dur);
    chk(dur == SECT_DUR, "R8 duration", dur, SECT_DUR);
    chk(erase_mask_o == NS'(1), "R8 mask", erase_mask_o, 1);
    step();
    chk(!done_o, "R8 done one cycle", done_o, 0);
    rd(0);
    chk(!rd_status_o && !rs_v, "R8 data after done", rs_v, 0);
  endtask

  task automatic t_multi;
    int c0, c1, dur;
    sect(64, c0); step(2);
    sect(490, c1);
    sect(500, c1);
    wait_done(c1, dur);
    chk(dur == SECT_DUR, "R4 window restart", dur, SECT_DUR);
    chk(erase_mask_o == 11'b110_0000_0010, "R4 multi mask", erase_mask_o, 11'b110_0000_0010);
    step();
    sect(447, c0); sect(448, c0); sect(485, c0);
    wait_done(c0, dur);
    chk(erase_mask_o == 11'b001_1100_0000, "R5 region edges", erase_mask_o, 11'b001_1100_0000);
  endtask

  task automatic t_late;
    int c0, c1, dur;
    sect(0, c0); step(30);
    sect(64, c1);
    wait_done(c0, dur);
    chk(dur == SECT_DUR, "R4 late ignored duration", dur, SECT_DUR);
    chk(erase_mask_o == NS'(1), "R4 late ignored mask", erase_mask_o, 1);
  endtask

  task automatic t_susp_busy;
    int c0, s, r, dur; logic [7:0] s0;
    sect(0, c0); step(20);
    susp(s);
    rd(0);
    chk(rs_v, "R6 selected status", rs_v, 1);
    s0 = rs_st;
    rd(0);
    chk(rs_st[6] == s0[6], "R6 bit6 held", rs_st[6], s0[6]);
    chk(rs_st[2] == ~s0[2], "R6 bit2 flips", rs_st[2], ~s0[2]);
    rd(64);
    chk(!rs_v, "R6 other sector data", rs_v, 0);
    step(5);
    sect(200, r);
    rd(64);
    chk(rs_v && rs_st[3], "R7 resume status everywhere", {rs_v, rs_st[3]}, 3);
    s0 = rs_st;
    rd(64);
    chk(rs_st[6] == ~s0[6], "R7 bit6 toggles again", rs_st[6], ~s0[6]);
    wait_done(c0, dur);
    chk(dur == SECT_DUR + (r - s + 1), "R7 paused time", dur, SECT_DUR + (r - s + 1));
    chk(erase_mask_o == NS'(1), "R7 resume adds nothing", erase_mask_o, 1);
  endtask

  task automatic t_susp_window;
    int c0, s, r, dur;
    sect(0, c0); step(3);
    susp(s);
    rd(0);
    chk(rs_v, "R6 window suspend status", rs_v, 1);
    step(40);
    chk(busy_o && !done_o, "R6 suspended holds", busy_o, 1);
    sect(0, r);
    rd(0);
    chk(rs_st[3] == 1, "R7 bit3 after resume", rs_st[3], 1);
    wait_done(r, dur);
    chk(dur == ERS + 1, "R7 erase after window resume", dur, ERS + 1);
  endtask

  task automatic t_chip;
    int c0, s, dur; logic [7:0] s0;
    chip(c0);
    rd(100);
    chk(rs_v && rs_st[3] && !rs_st[7], "R9 no window", rs_st, 8'h08);
    s0 = rs_st;
    susp(s);
    rd(100);
    chk(rs_v && rs_st[6] == ~s0[6], "R9 suspend ignored", rs_st[6], ~s0[6]);
    wait_done(c0, dur);
    chk(dur == CHIP_DUR, "R9 duration", dur, CHIP_DUR);
    chk(&erase_mask_o, "R9 all sectors", erase_mask_o, 11'h7ff);
  endtask

  task automatic t_ignored;
    int c0, x, dur;
    susp(x);
    step();
    chk(!busy_o, "R10 idle suspend", busy_o, 0);
    sect(0, c0); step(20);
    chip(x);
    step();
    chk(erase_mask_o == NS'(1), "R10 chip while busy", erase_mask_o, 1);
    wait_done(c0, dur);
    chk(dur == SECT_DUR, "R10 chip while busy duration", dur, SECT_DUR);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    step(2);
    t_reset();
    t_single();
    t_multi();
    t_late();
    t_susp_busy();
    t_susp_window();
    t_chip();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule